// File: doc/BRIEF.md
# I2C Target Address Matcher

This block decides, during the address phase of an I2C transfer, whether the local target answers. A bit-level receiver, outside this block, hands over whole address bytes on a valid/ready stream. The byte carries the seven address bits in positions 7..1 and the R/W bit in position 0, where 1 means read. A side flag marks the first byte after a START or a repeated START. For every byte it accepts, the block returns one ACK/NACK decision. On a full match it also sets a sticky match flag and reports the direction, the matched code and which source matched. It then holds the clock low until software pulses the flag-clear input.

Two own-address slots are compared. The first is either an exact 7-bit address or a 10-bit address. The second is a 7-bit address whose lowest bits can be ignored, with a 3-bit ignore setting. A general-call response to address 0 can be switched on. In 10-bit operation the reported code is the 7-bit header `11110` plus the two top address bits. Software rebuilds the full address from that header and the low byte that followed.

Stream rules: a byte moves on a rising edge where both `byte_valid` and `byte_ready` are high. `byte_ready` is low for as long as the match flag stands, so the receiver must keep its byte and `byte_valid` steady and wait. This back-pressure is the same condition as `scl_hold`. The response comes out as a one-cycle `resp_valid` pulse and cannot be stalled.

Top module: `i2c_tam`

## Requirements
- R1: After reset `resp_valid`, `match_flag` and `scl_hold` are low and `byte_ready` is high.
- R2: With slot one enabled in 7-bit mode, a first byte whose bits 7..1 equal `own1_addr[6:0]` is answered, on the edge after acceptance, with `resp_valid`=1 and `resp_ack`=1. The same edge sets `match_flag`, makes `match_rd` equal bit 0, makes `match_code` the 7-bit address and makes `match_src`=1.
- R3: Slot two with ignore setting n (0..6) ignores the n lowest bits of the 7-bit address and compares the rest; setting 0 compares all seven. A hit reports `match_src`=2 and the received address as the code.
- R4: With ignore setting 7, slot two accepts every 7-bit address except the reserved ones, whose top four bits are 0000 or 1111. Slot two never accepts a reserved address under any setting.
- R5: Address 0 with R/W=0 is acknowledged through general call only while `gcall_en` is high. It reports `match_src`=3, code 0 and write direction.
- R6: A slot whose enable is low matches nothing.
- R7: When several sources match, slot one wins over slot two, and slot two wins over general call.
- R8: With `own1_10b` high, slot one ignores 7-bit addresses. A first byte `11110 a9 a8 0` that matches `own1_addr[9:8]` is acknowledged without setting the flag. A following non-first byte equal to `own1_addr[7:0]` is acknowledged and sets the flag: write, code `{11110,a9,a8}`, source 1. A mismatching low byte is refused.
- R9: After a full 10-bit write match, a first byte `11110 a9 a8 1` is acknowledged as a read with the header code. Without that earlier match, or after any other first byte, it is refused.
- R10: `match_flag` and `scl_hold` stay high and `byte_ready` stays low until `flag_clr` is pulsed. The flag drops on the next edge.
- R11: Any other byte, including a non-first byte that no 10-bit header asked for, gets `resp_ack`=0 and leaves `match_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| own1_en | input | 1 | Slot one enable |
| own1_10b | input | 1 | Slot one in 10-bit mode |
| own1_addr | input | 10 | Slot one address (bits 6..0 in 7-bit mode) |
| own2_en | input | 1 | Slot two enable |
| own2_addr | input | 7 | Slot two 7-bit address |
| own2_ign | input | 3 | Slot two count of ignored low bits (7 = any non-reserved) |
| gcall_en | input | 1 | General-call response enable |
| byte_valid | input | 1 | Address byte present |
| byte_ready | output | 1 | Block can take the byte |
| byte_data | input | 8 | Address bits 7..1, R/W in bit 0 |
| byte_first | input | 1 | Byte is the first after START or repeated START |
| flag_clr | input | 1 | Clear the match flag, releasing the clock |
| resp_valid | output | 1 | One-cycle pulse carrying the ACK decision |
| resp_ack | output | 1 | 1 = acknowledge, 0 = refuse |
| match_flag | output | 1 | Sticky address-match flag |
| match_rd | output | 1 | Direction of the match, 1 = read |
| match_code | output | 7 | Matched 7-bit address or 10-bit header |
| match_src | output | 2 | 1 slot one, 2 slot two, 3 general call |
| scl_hold | output | 1 | Clock-stretch request |

## Verification
Two functions can meet in the same cycle: the software release of a standing flag, and the next address byte already waiting on the stream. The bench leaves a byte waiting on `byte_valid` while the flag stands. A parallel process checks that no response appears and that the hold stays on over several cycles, then pulses the clear. The scoreboard must then see exactly one response for the waiting byte, after the release and never before it.

// File: rtl/i2c_tam_pkg.sv
package i2c_tam_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TWO  = 2'd2,
    SRC_GC   = 2'd3
  } src_e;

  localparam logic [4:0] TEN_HDR = 5'b11110;
endpackage

// File: rtl/i2c_tam_mask_cmp.sv
module i2c_tam_mask_cmp #(
  parameter int A_W   = 7,
  parameter int IGN_W = 3
) (
  input  logic             en,
  input  logic [A_W-1:0]   own,
  input  logic [A_W-1:0]   rx,
  input  logic [IGN_W-1:0] ign,
  output logic             hit
);
  logic [A_W-1:0] care;
  logic [3:0]     top4;
  logic           rsvd;

  for (genvar i = 0; i < A_W; i++) begin : g_care
    assign care[i] = (int'(ign) <= i);
  end

  assign top4 = rx[A_W-1 -: 4];
  assign rsvd = (top4 == 4'h0) || (top4 == 4'hF);
  assign hit  = en && !rsvd && (((own ^ rx) & care) == '0);
endmodule

// File: rtl/i2c_tam_ten_track.sv
module i2c_tam_ten_track
  import i2c_tam_pkg::*;
#(
  parameter int A10_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             first,
  input  logic [7:0]       data,
  input  logic             en,
  input  logic             ten,
  input  logic [A10_W-1:0] own,
  output logic             t_ack,
  output logic             t_hit,
  output logic             t_rd,
  output logic [6:0]       t_code
);
  logic wait_lo, armed;
  logic hdr_ok, lo_ok;

  assign hdr_ok = en && ten && (data[7:3] == TEN_HDR) && (data[2:1] == own[A10_W-1 -: 2]);
  assign lo_ok  = en && ten && (data == own[7:0]);
  assign t_code = {TEN_HDR, own[A10_W-1 -: 2]};

  always_comb begin
    t_ack = 1'b0;
    t_hit = 1'b0;
    t_rd  = 1'b0;
    if (first) begin
      if (hdr_ok && !data[0]) begin
        t_ack = 1'b1;
      end else if (hdr_ok && data[0] && armed) begin
        t_ack = 1'b1;
        t_hit = 1'b1;
        t_rd  = 1'b1;
      end
    end else if (wait_lo && lo_ok) begin
      t_ack = 1'b1;
      t_hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_lo <= 1'b0;
      armed   <= 1'b0;
    end else if (take) begin
      if (first) begin
        wait_lo <= hdr_ok && !data[0];
        armed   <= 1'b0;
      end else begin
        wait_lo <= 1'b0;
        armed   <= wait_lo && lo_ok;
      end
    end
  end
endmodule

// File: rtl/i2c_tam.sv
module i2c_tam
  import i2c_tam_pkg::*;
#(
  parameter int A7_W  = 7,
  parameter int A10_W = 10,
  parameter int IGN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own1_en,
  input  logic             own1_10b,
  input  logic [A10_W-1:0] own1_addr,
  input  logic             own2_en,
  input  logic [A7_W-1:0]  own2_addr,
  input  logic [IGN_W-1:0] own2_ign,
  input  logic             gcall_en,
  input  logic             byte_valid,
  output logic             byte_ready,
  input  logic [A7_W:0]    byte_data,
  input  logic             byte_first,
  input  logic             flag_clr,
  output logic             resp_valid,
  output logic             resp_ack,
  output logic             match_flag,
  output logic             match_rd,
  output logic [A7_W-1:0]  match_code,
  output logic [1:0]       match_src,
  output logic             scl_hold
);
  localparam int B_W = A7_W + 1;

  logic            take, rw;
  logic [A7_W-1:0] rx7;
  logic            s1_hit, s2_raw, s2_hit, gc_hit;
  logic            t_ack, t_hit, t_rd;
  logic [6:0]      t_code;
  logic            hit_now, ack_now, rd_now;
  logic [A7_W-1:0] code_now;
  src_e            src_now;

  assign take = byte_valid && byte_ready;
  assign rx7  = byte_data[B_W-1:1];
  assign rw   = byte_data[0];

  assign s1_hit = byte_first && own1_en && !own1_10b && (rx7 == own1_addr[A7_W-1:0]);
  assign s2_hit = byte_first && s2_raw;
  assign gc_hit = byte_first && gcall_en && (rx7 == '0) && !rw;

  i2c_tam_mask_cmp #(.A_W(A7_W), .IGN_W(IGN_W)) u_mask (
    .en  (own2_en),
    .own (own2_addr),
    .rx  (rx7),
    .ign (own2_ign),
    .hit (s2_raw)
  );

  i2c_tam_ten_track #(.A10_W(A10_W)) u_ten (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (take),
    .first  (byte_first),
    .data   (byte_data),
    .en     (own1_en),
    .ten    (own1_10b),
    .own    (own1_addr),
    .t_ack  (t_ack),
    .t_hit  (t_hit),
    .t_rd   (t_rd),
    .t_code (t_code)
  );

  always_comb begin
    hit_now  = 1'b1;
    src_now  = SRC_NONE;
    code_now = rx7;
    rd_now   = rw;
    if (t_hit) begin
      src_now  = SRC_ONE;
      code_now = A7_W'(t_code);
      rd_now   = t_rd;
    end else if (s1_hit) begin
      src_now  = SRC_ONE;
    end else if (s2_hit) begin
      src_now  = SRC_TWO;
    end else if (gc_hit) begin
      src_now  = SRC_GC;
      code_now = '0;
      rd_now   = 1'b0;
    end else begin
      hit_now  = 1'b0;
    end
    ack_now = hit_now || t_ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      match_flag <= 1'b0;
      match_rd   <= 1'b0;
      match_code <= '0;
      match_src  <= SRC_NONE;
    end else begin
      resp_valid <= take;
      if (take) resp_ack <= ack_now;
      if (flag_clr && match_flag) begin
        match_flag <= 1'b0;
      end else if (take && hit_now) begin
        match_flag <= 1'b1;
        match_rd   <= rd_now;
        match_code <= code_now;
        match_src  <= src_now;
      end
    end
  end

  assign byte_ready = !match_flag;
  assign scl_hold   = match_flag;
endmodule

// File: rtl/i2c_tam_chk.sv
module i2c_tam_chk
  import i2c_tam_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       own1_en,
  input logic       own2_en,
  input logic       gcall_en,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic       flag_clr,
  input logic       resp_valid,
  input logic       resp_ack,
  input logic       match_flag,
  input logic       match_rd,
  input logic [6:0] match_code,
  input logic [1:0] match_src,
  input logic       scl_hold
);
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && !flag_clr |=> match_flag && scl_hold);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && match_flag |=> !match_flag);

  // R11
  resp_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(byte_valid && byte_ready));

  // R2
  rise_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> resp_valid && resp_ack);

  // R5
  gcall_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && match_src == SRC_GC |-> match_code == 7'd0 && !match_rd);

  // R6
  ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ack |-> $past(own1_en || own2_en || gcall_en));

  // R4
  slot2_no_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) && match_src == SRC_TWO |->
      match_code[6:3] != 4'h0 && match_code[6:3] != 4'hF);
endmodule

bind i2c_tam i2c_tam_chk u_chk (.*);

// File: tb/i2c_tam_bench.sv
module i2c_tam_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       own1_en = 0, own1_10b = 0, own2_en = 0, gcall_en = 0;
  logic [9:0] own1_addr = '0;
  logic [6:0] own2_addr = '0;
  logic [2:0] own2_ign = '0;
  logic       byte_valid = 0, byte_first = 0, flag_clr = 0;
  logic [7:0] byte_data = '0;
  logic       byte_ready, resp_valid, resp_ack, match_flag, match_rd, scl_hold;
  logic [6:0] match_code;
  logic [1:0] match_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit    ack;
    bit    hit;
    bit    rd;
    int    code;
    int    src;
    string req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  i2c_tam u_i2c_tam (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops one expectation per response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q.size() == 0) begin
        check(0, "R11", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(resp_ack == e.ack, e.req, "ack", int'(resp_ack), int'(e.ack));
        check(match_flag == e.hit, e.req, "flag", int'(match_flag), int'(e.hit));
        if (e.hit) begin
          check(match_rd == e.rd, e.req, "dir", int'(match_rd), int'(e.rd));
          check(int'(match_code) == e.code, e.req, "code", int'(match_code), e.code);
          check(int'(match_src) == e.src, e.req, "src", int'(match_src), e.src);
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit first, input bit eack,
                      input bit ehit, input bit erd, input int ecode,
                      input int esrc, input string req);
    exp_t e;
    e.ack = eack; e.hit = ehit; e.rd = erd; e.code = ecode; e.src = esrc; e.req = req;
    q.push_back(e);
    @(negedge clk);
    byte_data  = b;
    byte_first = first;
    byte_valid = 1'b1;
    while (!byte_ready) @(negedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic clear_flag(input string req);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check(!match_flag && byte_ready && !scl_hold, req, "released after clear",
          int'(match_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "R10", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!resp_valid && !match_flag && !scl_hold && byte_ready, "R1", "reset state",
          int'(match_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: slot one exact 7-bit
    own1_en = 1; own1_addr = 10'h02A;
    send({7'h2A, 1'b0}, 1, 1, 1, 0, 'h2A, 1, "R2");
    check(scl_hold && !byte_ready, "R10", "hold while flagged", int'(scl_hold), 1);
    repeat (3) @(negedge clk);
    check(match_flag && scl_hold, "R10", "flag sticky", int'(match_flag), 1);
    clear_flag("R10");
    send({7'h2A, 1'b1}, 1, 1, 1, 1, 'h2A, 1, "R2");
    clear_flag("R10");
    // R11: mismatch and stray non-first byte
    send({7'h2B, 1'b0}, 1, 0, 0, 0, 0, 0, "R11");
    send({7'h2A, 1'b0}, 0, 0, 0, 0, 0, 0, "R11");

    // R3: slot two with ignored bits
    own1_en = 0; own2_en = 1; own2_addr = 7'h50; own2_ign = 3'd0;
    send({7'h51, 1'b0}, 1, 0, 0, 0, 0, 0, "R3");
    own2_ign = 3'd2;
    send({7'h53, 1'b1}, 1, 1, 1, 1, 'h53, 2, "R3");
    clear_flag("R3");
    send({7'h54, 1'b0}, 1, 0, 0, 0, 0, 0, "R3");

    // R4: ignore all, reserved refused
    own2_ign = 3'd7;
    send({7'h33, 1'b0}, 1, 1, 1, 0, 'h33, 2, "R4");
    clear_flag("R4");
    send({7'h05, 1'b0}, 1, 0, 0, 0, 0, 0, "R4");
    send({7'h7C, 1'b0}, 1, 0, 0, 0, 0, 0, "R4");

    // R5: general call
    send(8'h00, 1, 0, 0, 0, 0, 0, "R5");
    gcall_en = 1;
    send(8'h00, 1, 1, 1, 0, 0, 3, "R5");
    clear_flag("R5");
    send(8'h01, 1, 0, 0, 0, 0, 0, "R5");

    // R6: disabled slots
    gcall_en = 0; own2_ign = 3'd0; own2_en = 0;
    send({7'h50, 1'b0}, 1, 0, 0, 0, 0, 0, "R6");
    own1_addr = 10'h050;
    send({7'h50, 1'b0}, 1, 0, 0, 0, 0, 0, "R6");

    // R7: priority
    own1_en = 1; own2_en = 1;
    send({7'h50, 1'b0}, 1, 1, 1, 0, 'h50, 1, "R7");
    clear_flag("R7");
    own1_en = 0; own2_ign = 3'd7; gcall_en = 1; own2_addr = 7'h00;
    send(8'h00, 1, 1, 1, 0, 0, 3, "R7");
    clear_flag("R7");
    own1_en = 1; own1_addr = 10'h000;
    send(8'h00, 1, 1, 1, 0, 0, 1, "R7");
    clear_flag("R7");

    // R8/R9: 10-bit slot one
    own2_en = 0; gcall_en = 0; own1_10b = 1; own1_addr = 10'h2C5;
    send({7'h2C, 1'b0}, 1, 0, 0, 0, 0, 0, "R8");
    send({7'h7A, 1'b1}, 1, 0, 0, 0, 0, 0, "R9");
    send({7'h7A, 1'b0}, 1, 1, 0, 0, 0, 0, "R8");
    send(8'hC6, 0, 0, 0, 0, 0, 0, "R8");
    send({7'h7A, 1'b0}, 1, 1, 0, 0, 0, 0, "R8");
    send(8'hC5, 0, 1, 1, 0, 'h7A, 1, "R8");
    clear_flag("R8");
    send({7'h7A, 1'b1}, 1, 1, 1, 1, 'h7A, 1, "R9");
    clear_flag("R9");
    send({7'h7A, 1'b1}, 1, 0, 0, 0, 0, 0, "R9");

    // R10: byte waiting while flag stands, released by clear
    own1_10b = 0; own1_addr = 10'h02A;
    send({7'h2A, 1'b0}, 1, 1, 1, 0, 'h2A, 1, "R10");
    fork
      send({7'h2A, 1'b1}, 1, 1, 1, 1, 'h2A, 1, "R10");
      begin
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          check(scl_hold && !resp_valid && q.size() == 1, "R10", "stalled byte",
                int'(resp_valid), 0);
        end
        clear_flag("R10");
      end
    join
    clear_flag("R10");

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R11", "all responses seen", q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule